// File: doc/BRIEF.md
# Local Interrupt Vector Table Unit

This unit sits beside one processor core and collects five local interrupt sources: an internal down-counting timer, a thermal alarm pulse, a performance-counter overflow pulse and two external interrupt pins. Each source has its own table entry. The entry holds an 8-bit vector, a 3-bit delivery mode, a mask bit and, for the timer, a periodic/one-shot selector. An unmasked source event sets a pending bit. Among the pending sources whose vector class beats the task priority threshold, the unit offers the one with the highest vector to the core through a request/vector/acknowledge handshake.

Software reaches the unit through a flat register port with a single write strobe and a combinational read. There are five table entries, the timer initial count, the live timer count and the task priority register. The priority class of a vector or of the task priority value is its upper nibble.

Top module: `lit_unit`

## Requirements
- R1: After reset every entry reads 0x0001_0000 (masked, vector 0, mode 0), the task priority and both timer counts read 0, and irq_req_o is low.
- R2: Addresses 0..4 select the entries for timer, thermal, perf overflow, ext pin 0 and ext pin 1. Entry bits are [7:0] vector, [10:8] mode, [16] mask (1 = masked) and [17] periodic. Other bits read 0. Address 5 is the initial count, 6 the current count (read-only) and 7 the task priority [7:0].
- R3: An event on a masked source is discarded. Unmasking the entry afterwards produces no request.
- R4: An event on an unmasked source raises irq_req_o on the next cycle. irq_vec_o and irq_mode_o then carry that entry's vector and mode.
- R5: A pending vector is offered only if its class (bits 7:4) is strictly greater than the task priority class (bits 7:4).
- R6: With several sources pending, the highest vector is offered first. irq_ack_i clears only the offered source's pending bit.
- R7: Writing initial count N>0 loads the timer with N. It decrements once per clock, and N cycles after the write it sets the timer pending bit. In one-shot mode it then stays at 0.
- R8: In periodic mode the timer reloads N when it fires and fires again every N cycles.
- R9: Writing an initial count of 0 stops the timer at 0 and generates no interrupt.
- R10: Reading address 6 returns the live timer value in every cycle.
- R11: Lowering the task priority releases a pending vector that was previously held back, without a new event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i |
| thermal_evt_i | input | 1 | Thermal threshold crossing pulse |
| perf_ovf_i | input | 1 | Performance counter overflow pulse |
| ext_irq_i | input | 2 | External interrupt pin pulses |
| irq_req_o | output | 1 | Interrupt request to core |
| irq_vec_o | output | 8 | Offered vector |
| irq_mode_o | output | 3 | Offered delivery mode |
| irq_ack_i | input | 1 | Core acknowledge of offered vector |

## Verification
The bench builds the unit with the default 32-bit timer counter. This keeps the register read-back width-exact and lets small counts (1 to 5) exercise reload and expiry within a few cycles. A table of vector and threshold pairs walks the strict class comparison across its equal-class and adjacent-class edges on the thermal entry. Directed sequences then cover the three-way pending order, expiry timing at exact cycles, and stopping a periodic timer with a zero write.

// File: rtl/lit_pkg.sv
package lit_pkg;
  localparam int NSRC   = 5;
  localparam int VEC_W  = 8;
  localparam int MODE_W = 3;

  localparam int SRC_TMR  = 0;
  localparam int SRC_THM  = 1;
  localparam int SRC_PERF = 2;
  localparam int SRC_EXT0 = 3;
  localparam int SRC_EXT1 = 4;

  localparam logic [2:0] A_INIT = 3'd5;
  localparam logic [2:0] A_CUR  = 3'd6;
  localparam logic [2:0] A_TPR  = 3'd7;

  typedef struct packed {
    logic              periodic;
    logic              mask;
    logic [MODE_W-1:0] mode;
    logic [VEC_W-1:0]  vec;
  } ent_t;

  function automatic ent_t word2ent(logic [31:0] w);
    ent_t e;
    e.periodic = w[17];
    e.mask     = w[16];
    e.mode     = w[10:8];
    e.vec      = w[7:0];
    return e;
  endfunction

  function automatic logic [31:0] ent2word(ent_t e);
    return {14'd0, e.periodic, e.mask, 5'd0, e.mode, e.vec};
  endfunction
endpackage

// File: rtl/lit_entry.sv
module lit_entry
  import lit_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_i,
  input  logic [31:0] wdata_i,
  input  logic        evt_i,
  input  logic        clr_i,
  output ent_t        cfg_o,
  output logic        pend_o
);
  ent_t cfg_q;
  logic pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q      <= '0;
      cfg_q.mask <= 1'b1;
      pend_q     <= 1'b0;
    end else begin
      if (wr_i) cfg_q <= word2ent(wdata_i);
      // masked entry holds nothing; a new event wins over a same-cycle ack
      pend_q <= cfg_q.mask ? 1'b0 : ((pend_q & ~clr_i) | evt_i);
    end
  end

  assign cfg_o  = cfg_q;
  assign pend_o = pend_q;

  assert_mask_no_pend_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_q.mask |=> !pend_q);
endmodule

// File: rtl/lit_timer.sv
module lit_timer #(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             periodic_i,
  output logic             fire_o,
  output logic [CNT_W-1:0] init_o,
  output logic [CNT_W-1:0] count_o
);
  logic [CNT_W-1:0] cnt_q, init_q;
  logic             run_q;

  assign fire_o = run_q && !load_i && (cnt_q == CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      init_q <= '0;
      run_q  <= 1'b0;
    end else if (load_i) begin
      init_q <= load_val_i;
      cnt_q  <= load_val_i;
      run_q  <= (load_val_i != '0);
    end else if (fire_o) begin
      cnt_q  <= periodic_i ? init_q : '0;
      run_q  <= periodic_i;
    end else if (run_q) begin
      cnt_q  <= cnt_q - CNT_W'(1);
    end
  end

  assign init_o  = init_q;
  assign count_o = cnt_q;

  assert_oneshot_stop_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire_o && !periodic_i) |=> (count_o == '0 && !fire_o));
  assert_periodic_reload_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire_o && periodic_i) |=> (count_o == init_o));
  assert_zero_load_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && load_val_i == '0) |=> (count_o == '0 && !fire_o));
endmodule

// File: rtl/lit_arb.sv
module lit_arb
  import lit_pkg::*;
(
  input  logic [NSRC-1:0]             pend_i,
  input  logic [NSRC-1:0][VEC_W-1:0]  vec_i,
  input  logic [NSRC-1:0][MODE_W-1:0] mode_i,
  input  logic [3:0]                  tpr_cls_i,
  output logic                        req_o,
  output logic [VEC_W-1:0]            vec_o,
  output logic [MODE_W-1:0]           mode_o,
  output logic [NSRC-1:0]             sel_o
);
  localparam int IDX_W = $clog2(NSRC);
  logic [IDX_W-1:0] idx;

  always_comb begin
    req_o = 1'b0;
    vec_o = '0;
    idx   = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (pend_i[i] && (vec_i[i][7:4] > tpr_cls_i) && (!req_o || vec_i[i] > vec_o)) begin
        req_o = 1'b1;
        vec_o = vec_i[i];
        idx   = IDX_W'(i);
      end
    end
    mode_o = mode_i[idx];
    sel_o  = req_o ? (NSRC'(1) << idx) : '0;
  end
endmodule

// File: rtl/lit_unit.sv
module lit_unit
  import lit_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [2:0]        addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  input  logic              thermal_evt_i,
  input  logic              perf_ovf_i,
  input  logic [1:0]        ext_irq_i,
  output logic              irq_req_o,
  output logic [VEC_W-1:0]  irq_vec_o,
  output logic [MODE_W-1:0] irq_mode_o,
  input  logic              irq_ack_i
);
  ent_t [NSRC-1:0]              cfg;
  logic [NSRC-1:0]              pend, evt, clr, sel;
  logic [NSRC-1:0][VEC_W-1:0]   vecs;
  logic [NSRC-1:0][MODE_W-1:0]  modes;
  logic [7:0]                   tpr_q;
  logic                         tmr_fire;
  logic [CNT_W-1:0]             tmr_init, tmr_cnt;

  assign evt = {ext_irq_i[1], ext_irq_i[0], perf_ovf_i, thermal_evt_i, tmr_fire};
  assign clr = sel & {NSRC{irq_ack_i}};

  for (genvar g = 0; g < NSRC; g++) begin : g_ent
    lit_entry u_ent (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .wr_i   (wr_en_i && addr_i == 3'(g)),
      .wdata_i(wdata_i),
      .evt_i  (evt[g]),
      .clr_i  (clr[g]),
      .cfg_o  (cfg[g]),
      .pend_o (pend[g])
    );
    assign vecs[g]  = cfg[g].vec;
    assign modes[g] = cfg[g].mode;
  end

  lit_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (wr_en_i && addr_i == A_INIT),
    .load_val_i(wdata_i[CNT_W-1:0]),
    .periodic_i(cfg[SRC_TMR].periodic),
    .fire_o    (tmr_fire),
    .init_o    (tmr_init),
    .count_o   (tmr_cnt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          tpr_q <= '0;
    else if (wr_en_i && addr_i == A_TPR)  tpr_q <= wdata_i[7:0];
  end

  lit_arb u_arb (
    .pend_i   (pend),
    .vec_i    (vecs),
    .mode_i   (modes),
    .tpr_cls_i(tpr_q[7:4]),
    .req_o    (irq_req_o),
    .vec_o    (irq_vec_o),
    .mode_o   (irq_mode_o),
    .sel_o    (sel)
  );

  always_comb begin
    case (addr_i)
      A_INIT:  rdata_o = 32'(tmr_init);
      A_CUR:   rdata_o = 32'(tmr_cnt);
      A_TPR:   rdata_o = {24'd0, tpr_q};
      default: rdata_o = (int'(addr_i) < NSRC) ? ent2word(cfg[addr_i]) : '0;
    endcase
  end

  assert_class_gate_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_req_o |-> (irq_vec_o[7:4] > tpr_q[7:4]));
  assert_ack_clears_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_req_o && irq_ack_i && ((evt & sel) == '0)) |=> ((pend & $past(sel)) == '0));
  assert_req_needs_pend_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_req_o |-> (pend != '0));
endmodule

// File: tb/lit_unit_tb.sv
`timescale 1ns/1ps
module lit_unit_tb;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        wr_en = 1'b0, ack = 1'b0, thm = 1'b0, perf = 1'b0;
  logic [1:0]  ext = 2'b0;
  logic [2:0]  addr = 3'd0;
  logic [31:0] wdata = '0, rdata;
  logic        req;
  logic [7:0]  vec;
  logic [2:0]  mode;
  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  lit_unit u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .thermal_evt_i(thm), .perf_ovf_i(perf), .ext_irq_i(ext),
    .irq_req_o(req), .irq_vec_o(vec), .irq_mode_o(mode), .irq_ack_i(ack));

  typedef struct packed { logic [7:0] v; logic [7:0] t; logic e; } tv_t;
  localparam tv_t TV [8] = '{
    '{8'h35, 8'h20, 1'b1}, '{8'h35, 8'h30, 1'b0}, '{8'h35, 8'h3F, 1'b0},
    '{8'h40, 8'h3F, 1'b1}, '{8'hF0, 8'hE0, 1'b1}, '{8'h10, 8'h00, 1'b1},
    '{8'h0F, 8'h00, 1'b0}, '{8'h80, 8'hFF, 1'b0}};

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic do_ack();
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin : watchdog
    #(8 * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin : stim
    logic [31:0] d;
    wait_n(2);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 req", 32'(req), 0);
    for (int a = 0; a < 5; a++) begin rd(3'(a), d); chk("R1 entry", d, 32'h0001_0000); end
    rd(3'd5, d); chk("R1 init", d, 0);
    rd(3'd6, d); chk("R1 cur", d, 0);
    rd(3'd7, d); chk("R1 tpr", d, 0);

    // R2 field layout
    wr(3'd3, 32'hFFFF_FFFF); rd(3'd3, d); chk("R2 unused bits", d, 32'h0003_07FF);
    wr(3'd3, 32'h0003_05AB); rd(3'd3, d); chk("R2 readback", d, 32'h0003_05AB);
    wr(3'd7, 32'h0000_01C4); rd(3'd7, d); chk("R2 tpr width", d, 32'h0000_00C4);

    // R4/R5 table walk on thermal entry
    for (int i = 0; i < 8; i++) begin
      wr(3'd7, {24'd0, TV[i].t});
      wr(3'd1, {21'd0, 3'(i), TV[i].v});
      thm = 1'b1; @(negedge clk); thm = 1'b0;
      chk("R5 gate", 32'(req), 32'(TV[i].e));
      if (TV[i].e) begin
        chk("R4 vector", 32'(vec), 32'(TV[i].v));
        chk("R4 mode", 32'(mode), i);
        do_ack();
        chk("R6 ack clears", 32'(req), 0);
      end else begin
        wr(3'd1, 32'h0001_0000);
        chk("R3 mask clears", 32'(req), 0);
      end
    end

    // R11 threshold lowered releases held vector
    wr(3'd7, 32'h50);
    wr(3'd1, 32'h0000_0055);
    thm = 1'b1; @(negedge clk); thm = 1'b0;
    chk("R11 held", 32'(req), 0);
    wr(3'd7, 32'h40);
    chk("R11 released", 32'(req), 1);
    chk("R11 vector", 32'(vec), 32'h55);
    do_ack();
    wr(3'd7, 32'h0);

    // R3 masked event discarded
    wr(3'd1, 32'h0001_0090);
    thm = 1'b1; @(negedge clk); thm = 1'b0;
    wr(3'd1, 32'h0000_0090);
    wait_n(1);
    chk("R3 discarded", 32'(req), 0);

    // R6 ordering
    wr(3'd1, 32'h0000_0060);
    wr(3'd2, 32'h0000_0290);
    wr(3'd3, 32'h0000_0170);
    thm = 1'b1; perf = 1'b1; ext = 2'b01; @(negedge clk);
    thm = 1'b0; perf = 1'b0; ext = 2'b00;
    chk("R6 first", 32'(vec), 32'h90);
    chk("R6 first mode", 32'(mode), 2);
    do_ack(); chk("R6 second", 32'(vec), 32'h70);
    do_ack(); chk("R6 third", 32'(vec), 32'h60);
    do_ack(); chk("R6 drained", 32'(req), 0);

    // R7/R10 one-shot
    wr(3'd0, 32'h0000_00A0);
    wr(3'd5, 32'd5);
    rd(3'd6, d); chk("R10 loaded", d, 5);
    wait_n(2); rd(3'd6, d); chk("R10 live", d, 3);
    wait_n(2); chk("R7 not yet", 32'(req), 0);
    wait_n(1); chk("R7 fired", 32'(req), 1);
    chk("R7 vector", 32'(vec), 32'hA0);
    do_ack();
    wait_n(10);
    chk("R7 one-shot stays", 32'(req), 0);
    rd(3'd6, d); chk("R7 count zero", d, 0);

    // R8 periodic
    wr(3'd0, 32'h0002_00A1);
    wr(3'd5, 32'd4);
    wait_n(3); chk("R8 not yet", 32'(req), 0);
    wait_n(1); chk("R8 first fire", 32'(req), 1);
    rd(3'd6, d); chk("R8 reloaded", d, 4);
    do_ack();
    wait_n(2); chk("R8 gap", 32'(req), 0);
    wait_n(1); chk("R8 second fire", 32'(req), 1);
    do_ack();

    // R9 zero stops
    wr(3'd5, 32'd0);
    rd(3'd6, d); chk("R9 stopped", d, 0);
    wait_n(10);
    chk("R9 no interrupt", 32'(req), 0);
    rd(3'd6, d); chk("R9 stays zero", d, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule